// File: doc/BRIEF.md
# Triggered and Continuous Stream Framer

This block takes a flow of 32-bit samples, qualified by a valid flag, and turns them into a framed output stream with valid, ready, last and a one-bit user sideband. It has two modes of acquisition. A triggered acquisition sends exactly one buffer of a programmed length. When the header option is on, a fixed set of header words, supplied on an input bus, takes the first positions of that buffer. A continuous acquisition sends back-to-back frames of a fixed size, which is a parameter set to 4096 bytes by default. It keeps going until the enable input is removed.

An acquisition starts only when all of these hold in the same cycle: the trigger is pulsed, the enable is high, the input samples are valid, the downstream side is ready and pause is low. The block has no buffering. Once an acquisition runs, every cycle must move one word. If downstream back-pressure appears (ready low while valid is high), or if the input valid drops, the acquisition ends at once. A sticky error is then raised. The error and overflow flags clear when the next acquisition is accepted. In continuous mode, a freeze request seen during a frame is reported through the user bit on that frame's last beat. A 26-bit counter tallies every frame whose last beat is accepted downstream.

Top module: `sf_stream_framer`

## Requirements
- R1: An acquisition starts only on a clock edge where trig, enable, in_valid and t_ready are all high and pause is low, while no acquisition is running. The first beat shows t_valid high in the cycle after that edge.
- R2: In triggered mode (mode_cont = 0), the buffer holds buf_len beats. A buf_len below 14 is treated as 14. t_last is high on the final beat only, and t_valid is low in the cycle after that beat is accepted.
- R3: In triggered mode with hdr_en = 1, beats 0 to 13 carry hdr_words[32*i+31:32*i] for beat i, and the later beats carry samples. With hdr_en = 0, every beat is a sample. A sample beat carries the in_data value present at the clock edge that loaded the beat.
- R4: In continuous mode (mode_cont = 1), beats are grouped into frames of FRAME_WORDS beats, with t_last on the last beat of each frame and no gap between frames. hdr_en has no effect in this mode. The stream stops after the frame whose last beat is accepted while enable is low.
- R5: In continuous mode, a freeze pulse during a frame sets t_user on that frame's last beat. t_user is 0 on every other beat and always 0 in triggered mode.
- R6: While running, t_ready low with t_valid high ends the acquisition. t_valid goes low in the next cycle and both st_err and st_ovf are set. An in_valid drop at an accepted beat that does not finish the stream also ends the acquisition, and sets st_err but not st_ovf.
- R7: st_err and st_ovf stay set until the next accepted start, which clears both.
- R8: frame_cnt (26 bits, wrapping) increments by one on every accepted beat with t_last high.
- R9: st_pause follows pause, st_ready follows t_ready, and st_enabled follows enable, all without delay.
- R10: A trig pulse while an acquisition runs is ignored, so the buffer length and content are unchanged.
- R11: After reset, t_valid, t_last, t_user, st_err, st_ovf and frame_cnt are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Stream enable |
| mode_cont | input | 1 | 0 selects triggered mode, 1 selects continuous mode |
| hdr_en | input | 1 | Header insertion in triggered mode |
| buf_len | input | LEN_W | Triggered buffer length in 32-bit words |
| trig | input | 1 | Trigger pulse |
| pause | input | 1 | Blocks a start while high |
| freeze | input | 1 | Freeze request pulse |
| hdr_words | input | 448 | Fourteen header words, word i at bits 32*i+31:32*i |
| in_data | input | 32 | Sample data |
| in_valid | input | 1 | Sample valid |
| t_ready | input | 1 | Downstream ready |
| t_valid | output | 1 | Output beat valid |
| t_data | output | 32 | Output beat data |
| t_last | output | 1 | Last beat of a buffer or frame |
| t_user | output | 1 | Freeze flag on the last beat |
| st_pause | output | 1 | Pause status |
| st_ready | output | 1 | Downstream ready status |
| st_ovf | output | 1 | Sticky back-pressure overflow |
| st_err | output | 1 | Sticky acquisition error |
| st_enabled | output | 1 | Enable status |
| frame_cnt | output | 26 | Frames sent |

## Verification
Triggered buffers are run with the header off, with the header on, and with a length below the minimum. This separates header placement from sample alignment and from length clamping. A continuous run spans three frames, with a freeze in the middle frame and the enable dropped in the last frame. It shows the wraparound without a gap, that t_user appears only on the right last beat, and that the stream stops at a frame boundary. Separate runs break ready and valid in the middle of a buffer, which tells the overflow error apart from the plain error. Start attempts that each lack one qualifier, and a retrigger in the middle of a buffer, show that only a fully qualified trigger in the idle state has any effect.

// File: rtl/sf_pkg.sv
package sf_pkg;
  localparam int unsigned SF_HDR_WORDS = 14;
  localparam int unsigned SF_WORD_W    = 32;
  localparam int unsigned SF_FC_W      = 26;
  typedef enum logic {SF_IDLE = 1'b0, SF_RUN = 1'b1} sf_state_e;
endpackage

// File: rtl/sf_ctrl.sv
module sf_ctrl
  import sf_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  input  logic enable,
  input  logic pause,
  input  logic in_valid,
  input  logic t_ready,
  input  logic t_valid,
  input  logic t_last,
  input  logic mode_cont,
  input  logic hdr_en,
  output logic start,
  output logic advance,
  output logic stop,
  output logic running,
  output logic run_cont,
  output logic run_hdr,
  output logic err,
  output logic ovf
);
  sf_state_e state_q;
  logic acc, ending, ready_drop, valid_drop, finish;

  always_comb begin
    running    = (state_q == SF_RUN);
    start      = !running && trig && enable && in_valid && t_ready && !pause;
    acc        = running && t_valid && t_ready;
    ending     = t_last && (!run_cont || !enable);
    ready_drop = running && t_valid && !t_ready;
    valid_drop = acc && !in_valid && !ending;
    finish     = acc && ending;
    advance    = acc && !ending && in_valid;
    stop       = ready_drop || valid_drop || finish;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= SF_IDLE;
      run_cont <= 1'b0;
      run_hdr  <= 1'b0;
      err      <= 1'b0;
      ovf      <= 1'b0;
    end else if (start) begin
      state_q  <= SF_RUN;
      run_cont <= mode_cont;
      run_hdr  <= hdr_en && !mode_cont;
      err      <= 1'b0;
      ovf      <= 1'b0;
    end else if (stop) begin
      state_q <= SF_IDLE;
      if (ready_drop || valid_drop) err <= 1'b1;
      if (ready_drop) ovf <= 1'b1;
    end
  end

  // R6: back-pressure during a run ends it with both flags raised
  a_r6_ready_drop_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (running && t_valid && !t_ready) |=> (!running && err && ovf));
  // R2: a triggered buffer ends after its last beat is taken
  a_r2_trig_single_buffer: assert property (@(posedge clk) disable iff (!rst_n)
    (running && t_valid && t_ready && t_last && !run_cont) |=> !running);
  // R4: continuous frames roll over without a gap while enabled
  a_r4_cont_rolls_over: assert property (@(posedge clk) disable iff (!rst_n)
    (running && t_valid && t_ready && t_last && run_cont && enable && in_valid) |=> running);
endmodule

// File: rtl/sf_beat_cnt.sv
module sf_beat_cnt
  import sf_pkg::*;
#(
  parameter int unsigned LEN_W       = 16,
  parameter int unsigned FRAME_WORDS = 1024
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             advance,
  input  logic             mode_cont,
  input  logic [LEN_W-1:0] buf_len,
  output logic [LEN_W-1:0] load_idx,
  output logic             load_last
);
  localparam logic [LEN_W-1:0] FRAME_LEN = LEN_W'(FRAME_WORDS);
  localparam logic [LEN_W-1:0] MIN_LEN   = LEN_W'(SF_HDR_WORDS);
  localparam logic [LEN_W-1:0] ONE       = LEN_W'(1);

  logic [LEN_W-1:0] idx_q, len_q, start_len, cur_len;

  always_comb begin
    if (mode_cont)              start_len = FRAME_LEN;
    else if (buf_len < MIN_LEN) start_len = MIN_LEN;
    else                        start_len = buf_len;
    cur_len = start ? start_len : len_q;
    if (start || (idx_q == len_q - ONE)) load_idx = '0;
    else                                 load_idx = idx_q + ONE;
    load_last = (load_idx == cur_len - ONE);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q <= '0;
      len_q <= MIN_LEN;
    end else if (start) begin
      idx_q <= '0;
      len_q <= start_len;
    end else if (advance) begin
      idx_q <= load_idx;
    end
  end

  // R2: the beat position never leaves the active length
  a_r2_idx_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q < len_q);
endmodule

// File: rtl/sf_beat_out.sv
module sf_beat_out
  import sf_pkg::*;
#(
  parameter int unsigned LEN_W = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           load,
  input  logic                           clear,
  input  logic [LEN_W-1:0]               load_idx,
  input  logic                           load_last,
  input  logic                           use_hdr,
  input  logic                           cont,
  input  logic                           freeze,
  input  logic [SF_WORD_W-1:0]           in_data,
  input  logic [SF_HDR_WORDS*SF_WORD_W-1:0] hdr_words,
  output logic                           t_valid,
  output logic [SF_WORD_W-1:0]           t_data,
  output logic                           t_last,
  output logic                           t_user
);
  localparam int unsigned HIDX_W = $clog2(SF_HDR_WORDS);

  logic [SF_WORD_W-1:0] hdr_arr [SF_HDR_WORDS];
  logic [SF_WORD_W-1:0] word;
  logic                 in_hdr;
  logic                 seen_q;

  for (genvar i = 0; i < SF_HDR_WORDS; i++) begin : g_hdr
    assign hdr_arr[i] = hdr_words[i*SF_WORD_W +: SF_WORD_W];
  end

  always_comb begin
    in_hdr = use_hdr && (load_idx < LEN_W'(SF_HDR_WORDS));
    word   = in_hdr ? hdr_arr[load_idx[HIDX_W-1:0]] : in_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      t_valid <= 1'b0;
      t_data  <= '0;
      t_last  <= 1'b0;
      t_user  <= 1'b0;
      seen_q  <= 1'b0;
    end else if (load) begin
      t_valid <= 1'b1;
      t_data  <= word;
      t_last  <= load_last;
      t_user  <= cont && load_last && (seen_q || freeze);
      seen_q  <= load_last ? 1'b0 : (seen_q || (cont && freeze));
    end else if (clear) begin
      t_valid <= 1'b0;
      t_last  <= 1'b0;
      t_user  <= 1'b0;
      seen_q  <= 1'b0;
    end
  end
endmodule

// File: rtl/sf_frame_cnt.sv
module sf_frame_cnt
  import sf_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               inc,
  output logic [SF_FC_W-1:0] frame_cnt
);
  always_ff @(posedge clk) begin
    if (!rst_n)   frame_cnt <= '0;
    else if (inc) frame_cnt <= frame_cnt + SF_FC_W'(1);
  end

  // R8: one count per accepted last beat
  a_r8_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    inc |=> (frame_cnt == $past(frame_cnt) + SF_FC_W'(1)));
  a_r8_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !inc |=> $stable(frame_cnt));
endmodule

// File: rtl/sf_stream_framer.sv
module sf_stream_framer
  import sf_pkg::*;
#(
  parameter int unsigned LEN_W       = 16,
  parameter int unsigned FRAME_WORDS = 1024
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enable,
  input  logic                 mode_cont,
  input  logic                 hdr_en,
  input  logic [LEN_W-1:0]     buf_len,
  input  logic                 trig,
  input  logic                 pause,
  input  logic                 freeze,
  input  logic [447:0]         hdr_words,
  input  logic [31:0]          in_data,
  input  logic                 in_valid,
  input  logic                 t_ready,
  output logic                 t_valid,
  output logic [31:0]          t_data,
  output logic                 t_last,
  output logic                 t_user,
  output logic                 st_pause,
  output logic                 st_ready,
  output logic                 st_ovf,
  output logic                 st_err,
  output logic                 st_enabled,
  output logic [25:0]          frame_cnt
);
  logic start, advance, stop, running, run_cont, run_hdr;
  logic [LEN_W-1:0] load_idx;
  logic load_last, sel_hdr, sel_cont;

  assign sel_hdr    = start ? (hdr_en && !mode_cont) : run_hdr;
  assign sel_cont   = start ? mode_cont : run_cont;
  assign st_pause   = pause;
  assign st_ready   = t_ready;
  assign st_enabled = enable;

  sf_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .trig(trig), .enable(enable), .pause(pause),
    .in_valid(in_valid), .t_ready(t_ready), .t_valid(t_valid), .t_last(t_last),
    .mode_cont(mode_cont), .hdr_en(hdr_en), .start(start), .advance(advance),
    .stop(stop), .running(running), .run_cont(run_cont), .run_hdr(run_hdr),
    .err(st_err), .ovf(st_ovf)
  );

  sf_beat_cnt #(.LEN_W(LEN_W), .FRAME_WORDS(FRAME_WORDS)) u_cnt (
    .clk(clk), .rst_n(rst_n), .start(start), .advance(advance),
    .mode_cont(mode_cont), .buf_len(buf_len), .load_idx(load_idx),
    .load_last(load_last)
  );

  sf_beat_out #(.LEN_W(LEN_W)) u_out (
    .clk(clk), .rst_n(rst_n), .load(start || advance), .clear(stop),
    .load_idx(load_idx), .load_last(load_last), .use_hdr(sel_hdr),
    .cont(sel_cont), .freeze(freeze), .in_data(in_data), .hdr_words(hdr_words),
    .t_valid(t_valid), .t_data(t_data), .t_last(t_last), .t_user(t_user)
  );

  sf_frame_cnt u_fc (
    .clk(clk), .rst_n(rst_n), .inc(t_valid && t_ready && t_last),
    .frame_cnt(frame_cnt)
  );

  // R1: a new stream only follows a fully qualified trigger
  a_r1_start_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(t_valid) |-> $past(trig && enable && in_valid && t_ready && !pause));
  // R7: a fresh acquisition begins with clean flags
  a_r7_flags_clear_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(t_valid) |-> (!st_err && !st_ovf));
  // R5: the freeze marker belongs to continuous frames only
  a_r5_user_cont_only: assert property (@(posedge clk) disable iff (!rst_n)
    t_user |-> (run_cont && running));
  // R6: the output stays idle whenever no acquisition runs
  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !t_valid);
endmodule

// File: tb/sf_stream_framer_test.sv
module sf_stream_framer_test;
  localparam int FW = 24;

  logic clk = 1'b0, rst_n = 1'b0;
  logic enable = 1'b0, mode_cont = 1'b0, hdr_en = 1'b0, trig = 1'b0;
  logic pause = 1'b0, freeze = 1'b0, in_valid = 1'b0, t_ready = 1'b0;
  logic [15:0] buf_len = 16'd20;
  logic [447:0] hdr_words;
  logic [31:0] in_data = '0;
  logic t_valid, t_last, t_user, st_pause, st_ready, st_ovf, st_err, st_enabled;
  logic [31:0] t_data;
  logic [25:0] frame_cnt;
  int vectors = 0, fails = 0;
  int exp_fc = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sf_stream_framer #(.LEN_W(16), .FRAME_WORDS(FW)) uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .mode_cont(mode_cont),
    .hdr_en(hdr_en), .buf_len(buf_len), .trig(trig), .pause(pause),
    .freeze(freeze), .hdr_words(hdr_words), .in_data(in_data),
    .in_valid(in_valid), .t_ready(t_ready), .t_valid(t_valid),
    .t_data(t_data), .t_last(t_last), .t_user(t_user), .st_pause(st_pause),
    .st_ready(st_ready), .st_ovf(st_ovf), .st_err(st_err),
    .st_enabled(st_enabled), .frame_cnt(frame_cnt)
  );

  for (genvar i = 0; i < 14; i++) begin : g_h
    assign hdr_words[32*i +: 32] = 32'hA000_0000 + i;
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  // triggered buffer; retrig_at < 0 means no retrigger
  task automatic run_buffer(input string req, input int len_set, input int len_exp,
                            input bit hdr, input int base, input int retrig_at);
    @(negedge clk);
    mode_cont = 0; hdr_en = hdr; buf_len = 16'(len_set); enable = 1;
    trig = 1; in_valid = 1; t_ready = 1; in_data = base;
    for (int k = 0; k < len_exp; k++) begin
      @(negedge clk);
      check({req, " valid"}, t_valid, 1);
      check({req, " data"}, t_data, (hdr && k < 14) ? 32'hA000_0000 + k : base + k);
      check({req, " last"}, t_last, k == len_exp - 1);
      check("R5 user in trig", t_user, 0);
      trig = (k == retrig_at); in_data = base + k + 1;
    end
    @(negedge clk);
    trig = 0;
    exp_fc++;
    check({req, " end"}, t_valid, 0);
    check("R8 count", frame_cnt, exp_fc);
  endtask

  task automatic t_reset();
    check("R11 valid", t_valid, 0);
    check("R11 last", t_last, 0);
    check("R11 user", t_user, 0);
    check("R11 err", st_err, 0);
    check("R11 ovf", st_ovf, 0);
    check("R11 count", frame_cnt, 0);
  endtask

  task automatic t_status();
    @(negedge clk);
    pause = 1; t_ready = 0; enable = 0; #1;
    check("R9 pause", st_pause, 1);
    check("R9 ready", st_ready, 0);
    check("R9 enabled", st_enabled, 0);
    pause = 0; t_ready = 1; enable = 1; #1;
    check("R9 pause low", st_pause, 0);
    check("R9 ready high", st_ready, 1);
    check("R9 enabled high", st_enabled, 1);
  endtask

  task automatic t_start_gating();
    for (int b = 0; b < 4; b++) begin
      @(negedge clk);
      mode_cont = 0; buf_len = 16'd20;
      enable = (b != 0); in_valid = (b != 1); t_ready = (b != 2); pause = (b == 3);
      trig = 1;
      @(negedge clk);
      check("R1 blocked start", t_valid, 0);
      trig = 0; enable = 1; in_valid = 1; t_ready = 1; pause = 0;
    end
  endtask

  task automatic t_cont();
    int base = 32'h5000;
    @(negedge clk);
    mode_cont = 1; hdr_en = 1; enable = 1; trig = 1; in_valid = 1; t_ready = 1;
    in_data = base;
    for (int n = 0; n < 3*FW; n++) begin
      @(negedge clk);
      check("R4 valid", t_valid, 1);
      check("R4 data", t_data, base + n);
      check("R4 last", t_last, (n % FW) == FW - 1);
      check("R5 user", t_user, n == 2*FW - 1);
      trig = 0; in_data = base + n + 1;
      freeze = (n == FW + 6);
      if (n >= 2*FW + 12) enable = 0;
    end
    @(negedge clk);
    freeze = 0;
    exp_fc += 3;
    check("R4 stop after frame", t_valid, 0);
    check("R8 count cont", frame_cnt, exp_fc);
    enable = 1; mode_cont = 0; hdr_en = 0;
  endtask

  task automatic t_err_ready();
    @(negedge clk);
    mode_cont = 0; buf_len = 16'd20; trig = 1; in_valid = 1; t_ready = 1; in_data = 7;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      trig = 0;
    end
    t_ready = 0;
    @(negedge clk);
    check("R6 stop on ready", t_valid, 0);
    check("R6 err", st_err, 1);
    check("R6 ovf", st_ovf, 1);
    check("R8 no count", frame_cnt, exp_fc);
    t_ready = 1;
    @(negedge clk);
    check("R7 err held", st_err, 1);
  endtask

  task automatic t_err_valid();
    @(negedge clk);
    trig = 1; in_valid = 1; t_ready = 1;
    @(negedge clk);
    trig = 0;
    check("R7 err cleared", st_err, 0);
    check("R7 ovf cleared", st_ovf, 0);
    in_valid = 0;
    @(negedge clk);
    check("R6 stop on valid", t_valid, 0);
    check("R6 err valid", st_err, 1);
    check("R6 no ovf", st_ovf, 0);
    in_valid = 1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_status();
    t_start_gating();
    run_buffer("R2 plain", 20, 20, 0, 32'h100, -1);
    run_buffer("R3 header", 20, 20, 1, 32'h200, -1);
    run_buffer("R2 clamp", 5, 14, 0, 32'h300, -1);
    run_buffer("R10 retrig", 18, 18, 0, 32'h400, 5);
    t_cont();
    t_err_ready();
    t_err_valid();
    report();
  end
endmodule